// File: doc/BRIEF.md
# Split-Table Instruction Decoder

This block turns a 16-bit instruction word into a wide datapath control word. It does not use one table indexed by the whole opcode. It holds the control words in two small writable tables. Instructions of the register-only class all share one fixed 6-bit value in their top bits. For these, the 5-bit secondary opcode in bits [9:5] indexes a 32-entry table. Every other instruction indexes a 64-entry table with its top six bits. Those six bits include the short 3-bit opcodes, so immediate bits below bit 10 never change the index.

Some opcodes share the same top six bits. Each entry of the 64-entry table therefore carries a refine flag. When the flag is set, instruction bits [9:8] pick one of four override entries, and that entry supplies the control word instead. A lookup takes one clock cycle. The output valid flag follows the input strobe by one cycle. An all-zero control word marks the opcode as illegal.

Software or a boot sequencer fills the three tables through one write port. The port has a table select, an address, data and a write enable. Register-file access and execution happen elsewhere.

Top module: `insn_decode_top`

## Requirements
- R1: After reset all table entries hold zero and `out_valid` is low. A lookup made before any table write returns a zero control word with `out_illegal` high.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: When `in_insn[15:10]` equals the register-class prefix (default 6'b011111), the control word is entry `in_insn[9:5]` of the 32-entry table. Bits [4:0] have no effect on it.
- R4: For any other value of `in_insn[15:10]` whose 64-entry table entry has its refine flag clear, the control word is that entry. Bits [9:0] have no effect on it.
- R5: When that entry has its refine flag set, the control word is override entry `in_insn[9:8]`.
- R6: `out_illegal` is high exactly when `out_valid` is high and the control word is all zeros.
- R7: A write takes effect at the clock edge it is presented on. A lookup of the same entry presented in that same cycle returns the old contents. The next lookup returns the new contents.
- R8: Write select 0 targets the 32-entry table, 1 the 64-entry table and 2 the override file. `wr_data[24]` is the refine flag and is stored only by the 64-entry table. Select 3 writes nothing.
- R9: While `out_valid` is low, `out_ctrl` is all zeros and `out_illegal` is low.
- R10: The 64-entry table entry at the prefix address is never used: writing it changes no register-class result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| in_insn | input | 16 | Instruction word |
| wr_en | input | 1 | Table write enable |
| wr_sel | input | 2 | Table select (0 register class, 1 main, 2 override, 3 none) |
| wr_addr | input | 6 | Entry address (low bits used by smaller tables) |
| wr_data | input | 25 | {refine flag, control word} |
| out_valid | output | 1 | Control word valid |
| out_ctrl | output | 24 | Decoded control word |
| out_illegal | output | 1 | Opcode decodes to an all-zero word |

## Verification
The bench varies the low operand and immediate bits while it holds the opcode fields fixed. A design that let those bits reach an index would return a different control word for the same opcode. It writes a distinct word into the 64-entry slot at the prefix address. A decoder that forgot the class compare would return that word for register-class instructions. Refined entries are swept over all four values of bits [9:8], which catches an override indexed from the wrong field. A write and a lookup of one entry are issued in the same cycle, and the lookup must see the old word. A write through the spare select value is checked afterwards against all three tables.

// File: rtl/idec_pkg.sv
package idec_pkg;

  typedef enum logic [1:0] {
    TBL_REG  = 2'd0,
    TBL_MAIN = 2'd1,
    TBL_OVR  = 2'd2,
    TBL_NONE = 2'd3
  } tbl_sel_e;

endpackage

// File: rtl/idec_table.sv
module idec_table #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // registered read: a write in the same cycle is seen on the next read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      rdata <= mem[raddr];
      if (we) mem[waddr] <= wdata;
    end
  end

endmodule

// File: rtl/idec_route.sv
module idec_route
  import idec_pkg::*;
#(
  parameter int          INSN_W  = 16,
  parameter int          OP6_W   = 6,
  parameter int          OP5_W   = 5,
  parameter int          OP5_LSB = 5,
  parameter int          OVR_AW  = 2,
  parameter int          OVR_LSB = 8,
  parameter logic [5:0]  PREFIX  = 6'b011111,
  localparam int         OP6_LSB = INSN_W - OP6_W
) (
  input  logic [INSN_W-1:0] insn,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  output logic              is_reg,
  output logic [OP5_W-1:0]  reg_idx,
  output logic [OP6_W-1:0]  main_idx,
  output logic [OVR_AW-1:0] ovr_idx,
  output logic              we_reg,
  output logic              we_main,
  output logic              we_ovr
);

  function automatic logic [OP6_W-1:0] f_top(input logic [INSN_W-1:0] w);
    return w[OP6_LSB +: OP6_W];
  endfunction

  function automatic logic f_class_reg(input logic [OP6_W-1:0] top);
    return top == OP6_W'(PREFIX);
  endfunction

  tbl_sel_e sel;
  logic     insn_unused;

  assign main_idx    = f_top(insn);
  assign is_reg      = f_class_reg(main_idx);
  assign reg_idx     = insn[OP5_LSB +: OP5_W];
  assign ovr_idx     = insn[OVR_LSB +: OVR_AW];
  assign insn_unused = ^insn[OP5_LSB-1:0];

  assign sel     = tbl_sel_e'(wr_sel);
  assign we_reg  = wr_en && (sel == TBL_REG);
  assign we_main = wr_en && (sel == TBL_MAIN);
  assign we_ovr  = wr_en && (sel == TBL_OVR);

endmodule

// File: rtl/insn_decode_top.sv
module insn_decode_top #(
  parameter int         INSN_W  = 16,
  parameter int         CW_W    = 24,
  parameter int         OP6_W   = 6,
  parameter int         OP5_W   = 5,
  parameter int         OP5_LSB = 5,
  parameter int         OVR_AW  = 2,
  parameter int         OVR_LSB = 8,
  parameter logic [5:0] PREFIX  = 6'b011111,
  localparam int        REG_DEPTH  = 1 << OP5_W,
  localparam int        MAIN_DEPTH = 1 << OP6_W,
  localparam int        OVR_DEPTH  = 1 << OVR_AW,
  localparam int        WA_W       = OP6_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [CW_W:0]     wr_data,
  output logic              out_valid,
  output logic [CW_W-1:0]   out_ctrl,
  output logic              out_illegal
);

  logic              is_reg;
  logic [OP5_W-1:0]  reg_idx;
  logic [OP6_W-1:0]  main_idx;
  logic [OVR_AW-1:0] ovr_idx;
  logic              we_reg, we_main, we_ovr;

  logic [CW_W-1:0]   reg_rd;
  logic [CW_W:0]     main_rd;
  logic [CW_W-1:0]   ovr_rd;

  logic              sel_reg_q;
  logic              refine_hit;
  logic [CW_W-1:0]   ctrl_pick;

  idec_route #(
    .INSN_W(INSN_W), .OP6_W(OP6_W), .OP5_W(OP5_W), .OP5_LSB(OP5_LSB),
    .OVR_AW(OVR_AW), .OVR_LSB(OVR_LSB), .PREFIX(PREFIX)
  ) u_route (
    .insn(in_insn), .wr_en(wr_en), .wr_sel(wr_sel),
    .is_reg(is_reg), .reg_idx(reg_idx), .main_idx(main_idx), .ovr_idx(ovr_idx),
    .we_reg(we_reg), .we_main(we_main), .we_ovr(we_ovr)
  );

  idec_table #(.DEPTH(REG_DEPTH), .WIDTH(CW_W)) u_reg_tbl (
    .clk(clk), .rst_n(rst_n), .we(we_reg),
    .waddr(wr_addr[OP5_W-1:0]), .wdata(wr_data[CW_W-1:0]),
    .raddr(reg_idx), .rdata(reg_rd)
  );

  idec_table #(.DEPTH(MAIN_DEPTH), .WIDTH(CW_W + 1)) u_main_tbl (
    .clk(clk), .rst_n(rst_n), .we(we_main),
    .waddr(wr_addr[OP6_W-1:0]), .wdata(wr_data),
    .raddr(main_idx), .rdata(main_rd)
  );

  idec_table #(.DEPTH(OVR_DEPTH), .WIDTH(CW_W)) u_ovr_tbl (
    .clk(clk), .rst_n(rst_n), .we(we_ovr),
    .waddr(wr_addr[OVR_AW-1:0]), .wdata(wr_data[CW_W-1:0]),
    .raddr(ovr_idx), .rdata(ovr_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sel_reg_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      sel_reg_q <= is_reg;
    end
  end

  // collision fix-up: refine flag redirects to the override file
  assign refine_hit  = !sel_reg_q && main_rd[CW_W];
  assign ctrl_pick   = sel_reg_q  ? reg_rd :
                       refine_hit ? ovr_rd : main_rd[CW_W-1:0];
  assign out_ctrl    = out_valid ? ctrl_pick : '0;
  assign out_illegal = out_valid && (ctrl_pick == '0);

endmodule

// File: rtl/idec_checker.sv
module idec_checker #(
  parameter int         INSN_W = 16,
  parameter int         CW_W   = 24,
  parameter logic [5:0] PREFIX = 6'b011111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [INSN_W-1:0] in_insn,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              out_valid,
  input logic [CW_W-1:0]   out_ctrl,
  input logic              out_illegal,
  input logic              sel_reg_q,
  input logic              we_reg,
  input logic              we_main,
  input logic              we_ovr
);

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_ctrl == '0) && !out_illegal);

  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid && (out_ctrl == '0));

  a_r3_reg_class: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_insn[INSN_W-1 -: 6] == PREFIX) |=> sel_reg_q);

  a_r4_main_class: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (in_insn[INSN_W-1 -: 6] != PREFIX) |=> !sel_reg_q);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_reg, we_main, we_ovr}));

  a_r8_spare_sel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == 2'd3) |-> $countones({we_reg, we_main, we_ovr}) == 0);

endmodule

bind insn_decode_top idec_checker #(.INSN_W(INSN_W), .CW_W(CW_W), .PREFIX(PREFIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
  .wr_en(wr_en), .wr_sel(wr_sel), .out_valid(out_valid), .out_ctrl(out_ctrl),
  .out_illegal(out_illegal), .sel_reg_q(sel_reg_q),
  .we_reg(we_reg), .we_main(we_main), .we_ovr(we_ovr)
);

// File: tb/tb_insn_decode_top.sv
module tb_insn_decode_top;
  localparam int CLK_P = 10;
  localparam logic [5:0] PFX = 6'b011111;

  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0;
  logic [15:0] in_insn = '0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = '0;
  logic [5:0]  wr_addr = '0;
  logic [24:0] wr_data = '0;
  logic        out_valid, out_illegal;
  logic [23:0] out_ctrl;

  int checks = 0, errors = 0;

  logic [23:0] m_reg  [32];
  logic [23:0] m_main [64];
  logic        m_ref  [64];
  logic [23:0] m_ovr  [4];

  always #(CLK_P/2) clk = ~clk;

  insn_decode_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_ctrl(out_ctrl), .out_illegal(out_illegal)
  );

  function automatic logic [23:0] expect_cw(input logic [15:0] w);
    logic [5:0] top = w[15:10];
    if (top == PFX)   return m_reg[w[9:5]];
    if (m_ref[top])   return m_ovr[w[9:8]];
    return m_main[top];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [1:0] s, input logic [5:0] a, input logic [24:0] d);
    case (s)
      2'd0: m_reg[a[4:0]] = d[23:0];
      2'd1: begin m_main[a] = d[23:0]; m_ref[a] = d[24]; end
      2'd2: m_ovr[a[1:0]] = d[23:0];
      default: ;
    endcase
  endtask

  // entered and left at a falling edge
  task automatic do_write(input logic [1:0] s, input logic [5:0] a, input logic [24:0] d);
    wr_en = 1; wr_sel = s; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(s, a, d);
  endtask

  task automatic lookup(input string req, input logic [15:0] w);
    logic [23:0] e = expect_cw(w);
    in_valid = 1; in_insn = w;
    @(negedge clk);
    in_valid = 0;
    check(req, {31'd0, out_valid}, 32'd1);
    check(req, {8'd0, out_ctrl}, {8'd0, e});
    check("R6", {31'd0, out_illegal}, {31'd0, e == '0});
  endtask

  task automatic t_reset;
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R9 ctrl idle", {8'd0, out_ctrl}, 32'd0);
    check("R9 illegal idle", {31'd0, out_illegal}, 32'd0);
    lookup("R1 empty main", 16'h1234);
    lookup("R1 empty reg", {PFX, 5'd3, 5'd0});
  endtask

  task automatic t_fill;
    for (int i = 0; i < 32; i++) do_write(2'd0, 6'(i), {1'b0, 24'hA00000 | 24'(i + 1)});
    for (int i = 0; i < 64; i++) do_write(2'd1, 6'(i), {1'b0, 24'h500000 | 24'(i << 4) | 24'd1});
    for (int i = 0; i < 4; i++)  do_write(2'd2, 6'(i), {1'b0, 24'hC00000 | 24'(i + 9)});
    do_write(2'd1, 6'h2A, {1'b1, 24'h0BAD01});
    do_write(2'd1, PFX, {1'b0, 24'hDEAD77});
  endtask

  task automatic t_reg_class;
    lookup("R3 op5w 0", {PFX, 5'd0, 5'd0});
    lookup("R3 op5w 31", {PFX, 5'd31, 5'd17});
    lookup("R3 operand 0", {PFX, 5'd9, 5'd0});
    lookup("R3 operand 31", {PFX, 5'd9, 5'd31});
    lookup("R10 prefix slot unused", {PFX, 5'd12, 5'd5});
  endtask

  task automatic t_main;
    lookup("R4 short opcode imm 00", 16'b010_00000000_00011);
    lookup("R4 short opcode imm FF", 16'b010_11111111_11100);
    lookup("R4 op6 0", 16'h0000);
    lookup("R4 op6 63", 16'hFFFF);
    lookup("R4 op6 0x12 mixed", {6'h12, 10'h2C5});
  endtask

  task automatic t_refine;
    for (int k = 0; k < 4; k++) lookup("R5 override", {6'h2A, 2'(k), 8'h5A});
  endtask

  task automatic t_illegal;
    do_write(2'd1, 6'h03, 25'd0);
    lookup("R6 zero entry", {6'h03, 10'h155});
  endtask

  task automatic t_valid_gap;
    in_insn = 16'h4444;
    @(negedge clk);
    check("R2 no strobe", {31'd0, out_valid}, 32'd0);
    check("R9 ctrl gated", {8'd0, out_ctrl}, 32'd0);
    lookup("R2 strobe", 16'h4444);
    lookup("R2 back to back", 16'h8888);
  endtask

  task automatic t_same_cycle;
    logic [15:0] w = {6'h21, 10'h000};
    logic [23:0] old = expect_cw(w);
    wr_en = 1; wr_sel = 2'd1; wr_addr = 6'h21; wr_data = {1'b0, 24'h777777};
    in_valid = 1; in_insn = w;
    @(negedge clk);
    wr_en = 0; in_valid = 0;
    check("R7 old value", {8'd0, out_ctrl}, {8'd0, old});
    model_write(2'd1, 6'h21, {1'b0, 24'h777777});
    lookup("R7 new value", w);
  endtask

  task automatic t_spare_sel;
    do_write(2'd3, 6'h07, {1'b1, 24'h999999});
    lookup("R8 main untouched", {6'h07, 10'h0});
    lookup("R8 reg untouched", {PFX, 5'd7, 5'd0});
    lookup("R8 override untouched", {6'h2A, 2'd3, 8'h0});
    do_write(2'd2, 6'h01, {1'b1, 24'h0F0F0F});
    lookup("R8 override write", {6'h2A, 2'd1, 8'h0});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_main[i] = '0; m_ref[i] = 0; end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int i = 0; i < 4; i++)  m_ovr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_reg_class;
    t_main;
    t_refine;
    t_illegal;
    t_valid_gap;
    t_same_cycle;
    t_spare_sel;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule